// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block produces the active-low chip reset. A digitised supply-good signal from an analog comparator drives it, together with an external reset pin, a watchdog request and a software reset request. Reset asserts when the supply falls below threshold. On every release path, reset stays asserted for a fixed stretch time counted in clock cycles. The default is 100 ms at the configured clock. The supply monitor works only while its strap input is high and while firmware keeps the monitor selected.

Firmware sees a small cause register over a simple register bus. Bit 1 reads back as the power-on flag, which is set when the last reset came from the supply. The same bit position, when written, selects or deselects the supply monitor as a reset source. Writing 1 to bit 3 requests a software reset. Bit 0 records an external pin reset and bit 2 records a watchdog reset. Bits 7:4 read 0.

The sequencer has three states. SUPPLY_LOW holds reset while the supply is bad. STRETCH holds reset while the timeout runs. RUN releases reset. The transitions are as follows. SUPPLY_LOW goes to STRETCH when the supply is good or the monitor is off. STRETCH goes to SUPPLY_LOW on a supply failure, stays in STRETCH and restarts the count on any other request, and goes to RUN when the count ends. RUN goes to SUPPLY_LOW on a supply failure and to STRETCH on any other request.

Top module: `supply_rst_seq`

## Requirements
- R1: After `pwr_clr_n` is released, `rst_n_o` is 0 while the monitor is active and `vdd_ok_i` is 0. During RUN, a fall of `vdd_ok_i` drives `rst_n_o` low three clock edges later, once the signal has passed the two-stage synchroniser.
- R2: After `vdd_ok_i` rises, `rst_n_o` rises exactly 3 + HOLD_CYC clock edges later.
- R3: While `mon_en_i` is 0, changes on `vdd_ok_i` never cause a reset.
- R4: After a supply reset (power-up or supply failure), `reg_rdata_o` reads 8'h02: bit 1 is the power-on flag and every other bit is 0.
- R5: Holding `ext_rst_n_i` low drives `rst_n_o` low after three edges. `rst_n_o` rises 2 + HOLD_CYC edges after the pin returns high. The register then reads 8'h01 (bit 0 set, power-on flag cleared).
- R6: A one-cycle `wdt_req_i` pulse during RUN drops `rst_n_o` at the next edge. Release follows 1 + HOLD_CYC edges after the pulse, and the register reads 8'h04 (bit 2).
- R7: A register write during RUN with bit 3 set causes a software reset with the same timing as R6. The register then reads 8'h08.
- R8: A write during RUN with bit 1 = 0 deselects the monitor, so a supply fall does not cause a reset. Any later reset selects the monitor again.
- R9: A watchdog pulse and a software reset write in the same cycle give a single reset with release after 1 + HOLD_CYC edges. The register then reads 8'h0C.
- R10: When a supply failure and an external pin request are seen in the same cycle, the supply wins. The register reads 8'h02 and release follows the R2 timing.
- R11: Register writes while reset is asserted have no effect. A write with bit 1 = 0 during STRETCH leaves the monitor selected.
- R12: A new request during STRETCH restarts the timeout. Release comes 1 + HOLD_CYC edges after the last watchdog pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, assumed running during reset |
| pwr_clr_n | input | 1 | Asynchronous clear of the sequencer's own registers at first power |
| vdd_ok_i | input | 1 | Supply-above-threshold comparator output, asynchronous |
| mon_en_i | input | 1 | Supply monitor enable strap |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_req_i | input | 1 | Watchdog reset request, one-cycle synchronous pulse |
| reg_wr_i | input | 1 | Cause register write strobe |
| reg_wdata_i | input | 8 | Write data (bit 1 monitor select, bit 3 software reset) |
| reg_rdata_o | output | 8 | Cause register read data |
| rst_n_o | output | 1 | Chip reset, active low |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is a supply failure and an external pin request. Both inputs go low at the same falling edge, so both pass the equal-length synchronisers and reach the state machine together. The bench expects the supply to take priority: the flags read 8'h02 while reset is held, and the later release follows the supply timing. The second pair is a watchdog pulse and a software reset write driven in the same cycle. The scoreboard expects a single release after 1 + HOLD_CYC edges with both cause bits set (8'h0C).

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

    typedef enum logic [1:0] {
        ST_SUPPLY_LOW = 2'd0,
        ST_STRETCH    = 2'd1,
        ST_RUN        = 2'd2
    } rst_state_e;

    localparam int REG_W  = 8;
    localparam int FLAG_W = 4;

    // cause register bit positions; bit 1 is fixed by behaviour
    localparam int FLG_EXT = 0;
    localparam int FLG_POR = 1;
    localparam int FLG_WDT = 2;
    localparam int FLG_SW  = 3;

    typedef struct packed {
        logic sw;
        logic wdt;
        logic ext;
    } req_t;

endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
module rstseq_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg[s] <= RST_VAL;
                else         stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg[s] <= RST_VAL;
                else         stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/rstseq_timer.sv
`timescale 1ns/1ps
module rstseq_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic run,
    output logic done
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (run && !done) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rstseq_flags.sv
`timescale 1ns/1ps
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic             clk,
    input  logic             arst_n,
    input  logic             load_supply,
    input  logic             load_other,
    input  logic             accumulate,
    input  req_t             req,
    input  logic             wr_en,
    input  logic             wr_sel,
    output logic             mon_sel,
    output logic [REG_W-1:0] rdata
);

    localparam logic [FLAG_W-1:0] POR_ONLY = FLAG_W'(1) << FLG_POR;

    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] new_bits;

    always_comb begin
        new_bits          = '0;
        new_bits[FLG_EXT] = req.ext;
        new_bits[FLG_WDT] = req.wdt;
        new_bits[FLG_SW]  = req.sw;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            flags   <= POR_ONLY;
            mon_sel <= 1'b1;
        end else if (load_supply) begin
            flags   <= POR_ONLY;
            mon_sel <= 1'b1;
        end else if (load_other) begin
            flags   <= accumulate ? ((flags & ~POR_ONLY) | new_bits) : new_bits;
            mon_sel <= 1'b1;
        end else if (wr_en) begin
            mon_sel <= wr_sel;
        end
    end

    assign rdata = REG_W'(flags);

endmodule

// File: rtl/supply_rst_seq.sv
`timescale 1ns/1ps
module supply_rst_seq
    import rstseq_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned HOLD_MS = 100,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             pwr_clr_n,
    input  logic             vdd_ok_i,
    input  logic             mon_en_i,
    input  logic             ext_rst_n_i,
    input  logic             wdt_req_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             rst_n_o
);

    localparam int unsigned HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;

    rst_state_e state, state_nx;

    logic vdd_s;
    logic ext_n_s;
    logic mon_sel;
    logic tmr_done;
    logic supply_fail;
    logic other_req;
    logic in_run;
    req_t req;
    logic unused_wdata;

    assign unused_wdata = ^{reg_wdata_i[REG_W-1:FLG_SW+1], reg_wdata_i[FLG_WDT], reg_wdata_i[FLG_EXT]};

    rstseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_vdd_sync (
        .clk(clk), .arst_n(pwr_clr_n), .d(vdd_ok_i), .q(vdd_s)
    );

    rstseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ext_sync (
        .clk(clk), .arst_n(pwr_clr_n), .d(ext_rst_n_i), .q(ext_n_s)
    );

    assign in_run      = (state == ST_RUN);
    assign supply_fail = mon_en_i & mon_sel & ~vdd_s;
    assign req.ext     = ~ext_n_s;
    assign req.wdt     = wdt_req_i;
    assign req.sw      = reg_wr_i & reg_wdata_i[FLG_SW] & in_run;
    assign other_req   = req.ext | req.wdt | req.sw;

    rstseq_timer #(.LIMIT(HOLD_CYC)) i_timer (
        .clk(clk),
        .arst_n(pwr_clr_n),
        .clr((state != ST_STRETCH) | other_req),
        .run(state == ST_STRETCH),
        .done(tmr_done)
    );

    rstseq_flags i_flags (
        .clk(clk),
        .arst_n(pwr_clr_n),
        .load_supply(supply_fail),
        .load_other(~supply_fail & other_req & (state != ST_SUPPLY_LOW)),
        .accumulate(state == ST_STRETCH),
        .req(req),
        .wr_en(reg_wr_i & in_run),
        .wr_sel(reg_wdata_i[FLG_POR]),
        .mon_sel(mon_sel),
        .rdata(reg_rdata_o)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SUPPLY_LOW: if (!supply_fail) state_nx = ST_STRETCH;
            ST_STRETCH: begin
                if (supply_fail)     state_nx = ST_SUPPLY_LOW;
                else if (other_req)  state_nx = ST_STRETCH;
                else if (tmr_done)   state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (supply_fail)     state_nx = ST_SUPPLY_LOW;
                else if (other_req)  state_nx = ST_STRETCH;
            end
            default:                 state_nx = ST_SUPPLY_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge pwr_clr_n) begin
        if (!pwr_clr_n) state <= ST_SUPPLY_LOW;
        else            state <= state_nx;
    end

    always_comb begin
        rst_n_o = (state == ST_RUN);
    end

endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk
    import rstseq_pkg::*;
(
    input logic       clk,
    input logic       pwr_clr_n,
    input logic       rst_n_o,
    input logic [7:0] reg_rdata_o,
    input logic       supply_fail,
    input logic       other_req,
    input logic       tmr_done,
    input rst_state_e state
);

    assert_supply_hold_R1: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        supply_fail |=> !rst_n_o);

    assert_release_timed_R2: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        $rose(rst_n_o) |-> $past(tmr_done));

    assert_quiet_run_R3: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        (rst_n_o && !supply_fail && !other_req) |=> rst_n_o);

    assert_por_flag_R4: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        (state == ST_SUPPLY_LOW) |-> (reg_rdata_o == 8'h02));

    assert_other_clears_por_R5: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        (rst_n_o && other_req && !supply_fail) |=> (!rst_n_o && !reg_rdata_o[1]));

endmodule

bind supply_rst_seq rstseq_chk i_chk (
    .clk(clk),
    .pwr_clr_n(pwr_clr_n),
    .rst_n_o(rst_n_o),
    .reg_rdata_o(reg_rdata_o),
    .supply_fail(supply_fail),
    .other_req(other_req),
    .tmr_done(tmr_done),
    .state(state)
);

// File: tb/test_supply_rst_seq.sv
`timescale 1ns/1ps
module test_supply_rst_seq;

    localparam int CLK_PERIOD = 10;
    localparam int HZ   = 16000;
    localparam int MS   = 1;
    localparam int T    = (HZ / 1000) * MS;

    logic       clk = 1'b0;
    logic       pwr_clr_n = 1'b0;
    logic       vdd_ok = 1'b0;
    logic       mon_en = 1'b1;
    logic       ext_n = 1'b1;
    logic       wdt = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rst_n;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    logic prev_rst = 1'b0;

    typedef struct {
        int         rel_cyc;
        logic [7:0] flags;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    supply_rst_seq #(.CLK_HZ(HZ), .HOLD_MS(MS)) i_supply_rst_seq (
        .clk(clk), .pwr_clr_n(pwr_clr_n), .vdd_ok_i(vdd_ok), .mon_en_i(mon_en),
        .ext_rst_n_i(ext_n), .wdt_req_i(wdt), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .rst_n_o(rst_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    // monitor: pops one expected release per rising edge of reset
    always @(negedge clk) begin
        if (pwr_clr_n && rst_n && !prev_rst) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "unexpected release", cyc, -1);
            end else begin
                cur = sb_q.pop_front();
                chk(cyc == cur.rel_cyc, {cur.tag, " release cycle"}, cyc, cur.rel_cyc);
                chk(rdata == cur.flags, {cur.tag, " flags"}, int'(rdata), int'(cur.flags));
            end
        end
        prev_rst = rst_n;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_release(input int delta, input logic [7:0] fl, input string tag);
        exp_t e;
        e.rel_cyc = cyc + delta;
        e.flags   = fl;
        e.tag     = tag;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        tick(2);
    endtask

    // drive at current negedge was already done; check fall after `lat` edges
    task automatic check_fall(input int lat, input string tag);
        if (lat > 1) begin
            tick(lat - 1);
            chk(rst_n == 1'b1, {tag, " not yet low"}, int'(rst_n), 1);
        end
        tick(1);
        chk(rst_n == 1'b0, {tag, " low"}, int'(rst_n), 0);
    endtask

    task automatic check_stays_high(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick(1);
            chk(rst_n == 1'b1, tag, int'(rst_n), 1);
        end
    endtask

    task automatic pulse_wdt();
        wdt = 1'b1;
        tick(1);
        wdt = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] v);
        wr = 1'b1;
        wdata = v;
        tick(1);
        wr = 1'b0;
        wdata = 8'h00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        tick(3);
        pwr_clr_n = 1'b1;
        tick(4);
        // R1 R4: reset state with supply low
        chk(rst_n == 1'b0, "R1 held at power-up", int'(rst_n), 0);
        chk(rdata == 8'h02, "R4 power-on flags", int'(rdata), 2);

        // R2 R4: power-up release
        expect_release(3 + T, 8'h02, "R2 power-up");
        vdd_ok = 1'b1;
        drain();

        // R1 supply drop during run, R2 recovery
        vdd_ok = 1'b0;
        check_fall(3, "R1 supply drop");
        chk(rdata == 8'h02, "R4 supply-fail flags", int'(rdata), 2);
        tick(5);
        expect_release(3 + T, 8'h02, "R2 recovery");
        vdd_ok = 1'b1;
        drain();

        // R5 external pin
        ext_n = 1'b0;
        check_fall(3, "R5 ext pin");
        tick(4);
        expect_release(2 + T, 8'h01, "R5 ext release");
        ext_n = 1'b1;
        drain();

        // R6 watchdog
        expect_release(1 + T, 8'h04, "R6 watchdog");
        pulse_wdt();
        chk(rst_n == 1'b0, "R6 watchdog low", int'(rst_n), 0);
        drain();

        // R7 software reset
        expect_release(1 + T, 8'h08, "R7 software");
        reg_write(8'h08);
        chk(rst_n == 1'b0, "R7 software low", int'(rst_n), 0);
        drain();

        // R9 watchdog and software in the same cycle
        expect_release(1 + T, 8'h0C, "R9 joint");
        wdt = 1'b1;
        reg_write(8'h08);
        wdt = 1'b0;
        drain();

        // R8 deselect monitor, then reselect through a reset
        reg_write(8'h00);
        chk(rst_n == 1'b1, "R8 plain write no reset", int'(rst_n), 1);
        vdd_ok = 1'b0;
        check_stays_high(10, "R8 deselected monitor");
        vdd_ok = 1'b1;
        tick(4);
        expect_release(1 + T, 8'h04, "R8 reselect wdt");
        pulse_wdt();
        drain();
        vdd_ok = 1'b0;
        check_fall(3, "R8 reselected monitor");
        tick(3);
        expect_release(3 + T, 8'h02, "R8 recovery");
        vdd_ok = 1'b1;
        drain();

        // R3 monitor strap off
        mon_en = 1'b0;
        vdd_ok = 1'b0;
        check_stays_high(10, "R3 monitor disabled");
        vdd_ok = 1'b1;
        tick(4);
        mon_en = 1'b1;
        tick(2);

        // R10 supply failure and ext request together
        vdd_ok = 1'b0;
        ext_n = 1'b0;
        check_fall(3, "R10 joint drop");
        chk(rdata == 8'h02, "R10 supply wins", int'(rdata), 2);
        tick(5);
        expect_release(3 + T, 8'h02, "R10 release");
        vdd_ok = 1'b1;
        ext_n = 1'b1;
        drain();

        // R12 restart during stretch
        pulse_wdt();
        tick(4);
        expect_release(1 + T, 8'h04, "R12 restart");
        pulse_wdt();
        drain();

        // R11 write during reset ignored
        expect_release(1 + T, 8'h04, "R11 wdt");
        pulse_wdt();
        tick(2);
        reg_write(8'h00);
        drain();
        vdd_ok = 1'b0;
        check_fall(3, "R11 monitor still selected");
        tick(3);
        expect_release(3 + T, 8'h02, "R11 recovery");
        vdd_ok = 1'b1;
        drain();

        chk(sb_q.size() == 0, "scoreboard empty", sb_q.size(), 0);
        summary();
    end

endmodule